// File: doc/BRIEF.md
# Phase-Sequenced Multi-Lane SPI Flash Master

This block is an SPI master that runs one chip-select framed transfer built from up to eight programmable phases. Each phase picks its own direction (write or read), its lane width (one, two or four data lines) and its byte count. A command can go out on a single line, and the address, mode bits, dummy cycles and read data that follow can use four lines, all within one frame. A one-cycle start pulse launches the frame. The engine pulls the chip select low, runs the phases strictly from index 0 upward, and releases the chip select at the end. It then sets a sticky done flag and, when enabled, pulses an interrupt.

Transmit bytes come in through a valid/ready handshake. Received bytes leave as a one-cycle valid pulse with no backpressure, so a read phase with nobody listening acts as a dummy phase. SCK is a registered output of the system clock. A divider sets its half period, and the fastest rate is half the system clock. The IO lanes are split into output, output-enable and input signals for the pad ring.

Top module: `mlspi_master`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, spi_io_oe is 0, and busy, done, irq, rx_valid and tx_ready are 0.
- R2: A start pulse while idle pulls spi_cs_n low on the next clock edge. busy stays high from then until spi_cs_n rises, and spi_cs_n stays low over every phase. A start pulse while busy is ignored and launches no extra frame.
- R3: phase_num selects how many phases run, counted from index 0 upward. The value 0 is treated as 1, and values above 8 are treated as 8. Phases past that count put no SCK edge on the bus.
- R4: Lane code (2 bits per phase): 00 = one line, 01 = two lines, 10 or 11 = four lines. Bytes go out MSB first. On one line, a write drives IO0 and a read samples IO1. On two lines, bits [7:6] go first on IO1:IO0. On four lines, bits [7:4] go first on IO3:IO0.
- R5: SPI mode 0. SCK idles low, outputs change only while SCK is low, and inputs are sampled at the rising edge. SCK stays high for exactly clk_div+1 clocks and low for at least clk_div+1 clocks, so clk_div = 0 gives half the system clock.
- R6: During a write phase, spi_io_oe is set only for the lanes that phase uses (0001, 0011 or 1111). During read phases and outside a frame, spi_io_oe is 0000.
- R7: A write byte is taken on a clock where tx_ready and tx_valid are both high. While tx_valid is low, SCK is held low and the frame waits.
- R8: Every byte of a read phase is delivered as a one-cycle rx_valid pulse with rx_data, whether or not it is consumed.
- R9: A phase length field of value k moves k+1 bytes.
- R10: spi_cs_n rises no earlier than 2*(clk_div+1) clocks after the last falling edge of SCK.
- R11: done rises together with spi_cs_n and clears when the next start is accepted. irq is a one-cycle pulse at that point when irq_en is 1, and stays 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse for one frame |
| irq_en | input | 1 | Enable for the completion interrupt pulse |
| clk_div | input | DIV_W | SCK half period minus one, in system clocks |
| phase_num | input | $clog2(NPH)+1 | Number of phases to run |
| ph_write | input | NPH | Per-phase direction, 1 = write |
| ph_lanes | input | 2*NPH | Per-phase lane code, 2 bits each |
| ph_len | input | NPH*CNT_W | Per-phase byte count minus one |
| tx_data | input | 8 | Transmit byte |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine waits for a transmit byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data valid for one clock |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_io_out | output | 4 | Lane output values |
| spi_io_oe | output | 4 | Lane output enables |
| spi_io_in | input | 4 | Lane input values |

## Verification
The hardest case to reach from the ports is a phase boundary where the lane width and direction change at once, while a transmit byte arrives late. The output enables, the shift amount and the sample lanes must all switch in the low half of SCK that is stretched by the stall. The bench reaches this case with frames that alternate write and read phases on one, two and four lanes. It runs them at several divider values and drops tx_valid on a pseudo-random pattern. A slave model that counts SCK edges checks every lane bit and enable against its own phase bookkeeping.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } mlspi_state_e;

  // index of the last SCK step inside one byte for a lane code
  function automatic logic [2:0] final_step(input logic [1:0] enc);
    case (enc)
      2'b00:   return 3'd7;
      2'b01:   return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  // lanes driven during a write phase
  function automatic logic [3:0] lane_mask(input logic [1:0] enc);
    case (enc)
      2'b00:   return 4'b0001;
      2'b01:   return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // requested phase count folded into 1..max_ph
  function automatic int unsigned clamp_phases(input int unsigned req,
                                               input int unsigned max_ph);
    if (req == 0)      return 1;
    if (req > max_ph)  return max_ph;
    return req;
  endfunction

endpackage

// File: rtl/mlspi_div.sv
module mlspi_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mlspi_lane.sv
module mlspi_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       advance,
  input  logic       capture,
  input  logic [1:0] enc,
  input  logic [3:0] io_in,
  output logic [3:0] tx_lanes,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_sh;
  logic [7:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load) begin
        tx_sh <= load_byte;
      end else if (advance) begin
        case (enc)
          2'b00:   tx_sh <= {tx_sh[6:0], 1'b0};
          2'b01:   tx_sh <= {tx_sh[5:0], 2'b00};
          default: tx_sh <= {tx_sh[3:0], 4'b0000};
        endcase
      end
      if (capture) begin
        case (enc)
          2'b00:   rx_sh <= {rx_sh[6:0], io_in[1]};
          2'b01:   rx_sh <= {rx_sh[5:0], io_in[1:0]};
          default: rx_sh <= {rx_sh[3:0], io_in};
        endcase
      end
    end
  end

  always_comb begin
    case (enc)
      2'b00:   tx_lanes = {3'b000, tx_sh[7]};
      2'b01:   tx_lanes = {2'b00, tx_sh[7:6]};
      default: tx_lanes = tx_sh[7:4];
    endcase
  end

  assign rx_byte = rx_sh;
endmodule

// File: rtl/mlspi_master.sv
module mlspi_master
  import mlspi_pkg::*;
#(
  parameter int NPH   = 8,
  parameter int CNT_W = 8,
  parameter int DIV_W = 4,
  localparam int PH_W = $clog2(NPH),
  localparam int PC_W = PH_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 irq_en,
  input  logic [DIV_W-1:0]     clk_div,
  input  logic [PC_W-1:0]      phase_num,
  input  logic [NPH-1:0]       ph_write,
  input  logic [2*NPH-1:0]     ph_lanes,
  input  logic [NPH*CNT_W-1:0] ph_len,
  input  logic [7:0]           tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [7:0]           rx_data,
  output logic                 rx_valid,
  output logic                 busy,
  output logic                 done,
  output logic                 irq,
  output logic                 spi_cs_n,
  output logic                 spi_sck,
  output logic [3:0]           spi_io_out,
  output logic [3:0]           spi_io_oe,
  input  logic [3:0]           spi_io_in
);
  mlspi_state_e     state;
  logic [PH_W-1:0]  ph_idx;
  logic [CNT_W-1:0] byte_cnt;
  logic [2:0]       step;
  logic             trail_half;
  logic             tick;

  logic             cur_wr;
  logic [1:0]       cur_enc;
  logic [CNT_W-1:0] cur_len;
  logic [PC_W-1:0]  n_eff;
  logic             last_ph;
  logic [3:0]       tx_lanes;
  logic [7:0]       rx_byte;

  // named internal events
  logic ev_launch, ev_take, ev_rise, ev_fall, ev_byte_end, ev_phase_end;
  logic ev_frame_end, ev_close;

  assign cur_wr  = ph_write[ph_idx];
  assign cur_enc = ph_lanes[2*ph_idx +: 2];
  assign cur_len = ph_len[ph_idx*CNT_W +: CNT_W];
  assign n_eff   = PC_W'(clamp_phases(int'(phase_num), NPH));
  assign last_ph = ({1'b0, ph_idx} + PC_W'(1)) == n_eff;

  assign ev_launch    = (state == ST_IDLE) && start;
  assign ev_take      = (state == ST_LOAD) && cur_wr && tx_valid;
  assign ev_rise      = (state == ST_SHIFT) && tick && !spi_sck;
  assign ev_fall      = (state == ST_SHIFT) && tick && spi_sck;
  assign ev_byte_end  = ev_fall && (step == final_step(cur_enc));
  assign ev_phase_end = ev_byte_end && (byte_cnt == cur_len);
  assign ev_frame_end = ev_phase_end && last_ph;
  assign ev_close     = (state == ST_TRAIL) && tick && trail_half;

  assign tx_ready = (state == ST_LOAD) && cur_wr;

  mlspi_div #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  ((state == ST_SHIFT) || (state == ST_TRAIL)),
    .div  (clk_div),
    .tick (tick)
  );

  mlspi_lane u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_take),
    .load_byte(tx_data),
    .advance  (ev_fall && !ev_byte_end),
    .capture  (ev_rise && !cur_wr),
    .enc      (cur_enc),
    .io_in    (spi_io_in),
    .tx_lanes (tx_lanes),
    .rx_byte  (rx_byte)
  );

  always_comb begin
    spi_io_out = 4'b0000;
    spi_io_oe  = 4'b0000;
    if (((state == ST_LOAD) || (state == ST_SHIFT)) && cur_wr) begin
      spi_io_out = tx_lanes & lane_mask(cur_enc);
      spi_io_oe  = lane_mask(cur_enc);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ph_idx     <= '0;
      byte_cnt   <= '0;
      step       <= '0;
      trail_half <= 1'b0;
      spi_sck    <= 1'b0;
      spi_cs_n   <= 1'b1;
      busy       <= 1'b0;
      done       <= 1'b0;
      irq        <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
    end else begin
      irq      <= 1'b0;
      rx_valid <= ev_byte_end && !cur_wr;
      if (ev_byte_end && !cur_wr) rx_data <= rx_byte;
      case (state)
        ST_IDLE: begin
          if (ev_launch) begin
            spi_cs_n <= 1'b0;
            busy     <= 1'b1;
            done     <= 1'b0;
            ph_idx   <= '0;
            byte_cnt <= '0;
            step     <= '0;
            state    <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (!cur_wr || tx_valid) begin
            step  <= '0;
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (ev_rise) spi_sck <= 1'b1;
          if (ev_fall) begin
            spi_sck <= 1'b0;
            if (ev_byte_end) begin
              step <= '0;
              if (ev_frame_end) begin
                trail_half <= 1'b0;
                state      <= ST_TRAIL;
              end else if (ev_phase_end) begin
                ph_idx   <= ph_idx + 1'b1;
                byte_cnt <= '0;
                state    <= ST_LOAD;
              end else begin
                byte_cnt <= byte_cnt + 1'b1;
                state    <= ST_LOAD;
              end
            end else begin
              step <= step + 1'b1;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) trail_half <= 1'b1;
          if (ev_close) begin
            spi_cs_n <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b1;
            irq      <= irq_en;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mlspi_master_chk.sv
module mlspi_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       irq,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic [3:0] spi_io_out,
  input logic [3:0] spi_io_oe,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       ev_fall
);
  // R2
  frame_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  // R5
  sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_cs_n);

  // R5
  data_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_io_out));

  // R5
  fall_from_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> !spi_sck);

  // R6
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_io_oe == 4'b0000) || (spi_io_oe == 4'b0001) ||
    (spi_io_oe == 4'b0011) || (spi_io_oe == 4'b1111));

  // R6
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_io_oe != 4'b0000) |-> !spi_cs_n);

  // R7
  stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !spi_sck);

  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R11
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && spi_cs_n));

  // R11
  cs_release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> (done && !busy));
endmodule

bind mlspi_master mlspi_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .irq       (irq),
  .spi_cs_n  (spi_cs_n),
  .spi_sck   (spi_sck),
  .spi_io_out(spi_io_out),
  .spi_io_oe (spi_io_oe),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .ev_fall   (ev_fall)
);

// File: tb/mlspi_master_test.sv
module mlspi_master_test;
  localparam int NPH = 8;
  localparam int CNT_W = 8;
  localparam int DIV_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic irq_en = 1'b0;
  logic [DIV_W-1:0] clk_div = '0;
  logic [3:0] phase_num = 4'd1;
  logic [NPH-1:0] ph_write = '0;
  logic [2*NPH-1:0] ph_lanes = '0;
  logic [NPH*CNT_W-1:0] ph_len = '0;
  logic [7:0] tx_data;
  logic tx_valid = 1'b1;
  logic tx_ready;
  logic [7:0] rx_data;
  logic rx_valid, busy, done, irq, spi_cs_n, spi_sck;
  logic [3:0] spi_io_out, spi_io_oe;
  logic [3:0] spi_io_in = 4'hF;

  always #10 clk = ~clk;

  mlspi_master #(.NPH(NPH), .CNT_W(CNT_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .irq_en(irq_en),
    .clk_div(clk_div), .phase_num(phase_num), .ph_write(ph_write),
    .ph_lanes(ph_lanes), .ph_len(ph_len), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .busy(busy), .done(done), .irq(irq),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_io_out(spi_io_out),
    .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tx_val(input int i);
    return (i * 73 + 29) % 256;
  endfunction
  function automatic int rd_val(input int i);
    return (i * 37 + 5) % 256;
  endfunction
  function automatic int width_of(input int enc);
    if (enc == 0) return 1;
    if (enc == 1) return 2;
    return 4;
  endfunction

  // phase table of the bench
  int cfg_wr[NPH];
  int cfg_enc[NPH];
  int cfg_len[NPH];
  int cfg_n = 1;
  int cfg_div = 0;
  bit cfg_irq = 0;
  bit stall_on = 0;

  // transmit source
  int tx_idx = 0;
  assign tx_data = 8'(tx_val(tx_idx));
  always @(posedge clk) begin
    if (tx_ready && tx_valid) tx_idx <= tx_idx + 1;
  end

  // slave model state
  int m_ph, m_byte, m_k;
  int wr_ord = 0, rd_ord = 0, rx_seen = 0;
  int hi_len = 0, lo_len = 0, since_fall = 0;
  int frames_seen = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;
  logic [7:0] lfsr = 8'hA5;
  int w, val, bits, exp_oe;

  always @(negedge clk) begin
    if (rst_n) begin
      since_fall++;
      if (prev_cs && !spi_cs_n) begin
        m_ph = 0; m_byte = 0; m_k = 0; lo_len = 0;
        frames_seen++;
        check(busy == 1'b1, "R2 busy at frame start", int'(busy), 1);
      end
      if (!spi_sck && !prev_sck && !spi_cs_n) lo_len++;
      if (spi_sck && prev_sck) hi_len++;
      if (spi_sck && !prev_sck) begin
        check(spi_cs_n == 1'b0, "R2 cs low at SCK edge", int'(spi_cs_n), 0);
        check(m_ph < cfg_n, "R3 no edges past phase count", m_ph, cfg_n);
        check(lo_len >= cfg_div + 1, "R5 SCK low time", lo_len, cfg_div + 1);
        hi_len = 1;
        if (m_ph < cfg_n && cfg_wr[m_ph] != 0) begin
          w = width_of(cfg_enc[m_ph]);
          bits = (tx_val(wr_ord) >> (8 - w * (m_k + 1))) & ((1 << w) - 1);
          check(int'(spi_io_out) == bits, "R4 write lane bits", int'(spi_io_out), bits);
        end
      end
      if (!spi_sck && prev_sck) begin
        check(hi_len == cfg_div + 1, "R5 SCK high time", hi_len, cfg_div + 1);
        lo_len = 1;
        since_fall = 0;
        if (m_ph < cfg_n) begin
          w = width_of(cfg_enc[m_ph]);
          m_k++;
          if (m_k == 8 / w) begin
            m_k = 0;
            if (cfg_wr[m_ph] != 0) wr_ord++; else rd_ord++;
            m_byte++;
            if (m_byte == cfg_len[m_ph]) begin
              m_byte = 0;
              m_ph++;
            end
          end
        end
      end
      if (!prev_cs && spi_cs_n) begin
        check(since_fall >= 2 * (cfg_div + 1), "R10 CS hold after last edge",
              since_fall, 2 * (cfg_div + 1));
        check(m_ph == cfg_n, "R9 all bytes of all phases moved", m_ph, cfg_n);
        check(done == 1'b1 && busy == 1'b0, "R11 done with CS release", int'(done), 1);
        check(irq == cfg_irq, "R11 irq follows irq_en", int'(irq), int'(cfg_irq));
      end
      if (rx_valid) begin
        check(int'(rx_data) == rd_val(rx_seen), "R8 rx byte", int'(rx_data), rd_val(rx_seen));
        rx_seen++;
      end
      if (tx_ready) check(spi_sck == 1'b0, "R7 SCK low while waiting", int'(spi_sck), 0);
      // output enables every clock
      exp_oe = 0;
      if (!spi_cs_n && m_ph < cfg_n && cfg_wr[m_ph] != 0)
        exp_oe = (1 << width_of(cfg_enc[m_ph])) - 1;
      check(int'(spi_io_oe) == exp_oe, "R6 output enables", int'(spi_io_oe), exp_oe);
      // slave drives read lanes
      spi_io_in = 4'hF;
      if (!spi_cs_n && m_ph < cfg_n && cfg_wr[m_ph] == 0) begin
        w = width_of(cfg_enc[m_ph]);
        val = rd_val(rd_ord);
        bits = (val >> (8 - w * (m_k + 1))) & ((1 << w) - 1);
        if (w == 1) spi_io_in[1] = bits[0];
        else if (w == 2) spi_io_in[1:0] = 2'(bits);
        else spi_io_in = 4'(bits);
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tx_valid = stall_on ? (lfsr[0] & lfsr[2]) : 1'b1;
      prev_sck = spi_sck;
      prev_cs = spi_cs_n;
    end
  end

  task automatic set_ph(input int p, input int wr, input int enc, input int len);
    cfg_wr[p] = wr; cfg_enc[p] = enc; cfg_len[p] = len;
  endtask

  task automatic run_frame(input int div, input int pnum, input bit ien,
                           input bit stall, input bit poke);
    int exp_wr, exp_rd, n_eff, cnt, frames0;
    n_eff = (pnum == 0) ? 1 : ((pnum > NPH) ? NPH : pnum);
    exp_wr = tx_idx; exp_rd = rx_seen;
    for (int p = 0; p < NPH; p++) begin
      ph_write[p] = cfg_wr[p][0];
      ph_lanes[2*p +: 2] = 2'(cfg_enc[p]);
      ph_len[p*CNT_W +: CNT_W] = CNT_W'(cfg_len[p] - 1);
      if (p < n_eff) begin
        if (cfg_wr[p] != 0) exp_wr += cfg_len[p]; else exp_rd += cfg_len[p];
      end
    end
    clk_div = DIV_W'(div); phase_num = 4'(pnum); irq_en = ien;
    cfg_div = div; cfg_n = n_eff; cfg_irq = ien; stall_on = stall;
    frames0 = frames_seen;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(spi_cs_n == 1'b0, "R2 CS low after start", int'(spi_cs_n), 0);
    check(done == 1'b0, "R11 done cleared by start", int'(done), 0);
    cnt = 0;
    while (!done && cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 12) start = 1'b1;
      if (poke && cnt == 13) start = 1'b0;
    end
    check(cnt < 20000, "watchdog frame end", cnt, 20000);
    stall_on = 0;
    repeat (30) @(negedge clk);
    check(frames_seen == frames0 + 1, "R2 one frame per accepted start",
          frames_seen - frames0, 1);
    check(spi_cs_n == 1'b1 && busy == 1'b0, "R2 idle after frame", int'(busy), 0);
    check(tx_idx == exp_wr, "R7 write bytes taken", tx_idx, exp_wr);
    check(rx_seen == exp_rd, "R8 read bytes delivered", rx_seen, exp_rd);
  endtask

  initial begin
    for (int p = 0; p < NPH; p++) set_ph(p, 1, 0, 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 1'b1, "R1 cs_n", int'(spi_cs_n), 1);
    check(spi_sck == 1'b0, "R1 sck", int'(spi_sck), 0);
    check(spi_io_oe == 4'b0, "R1 oe", int'(spi_io_oe), 0);
    check({busy, done, irq, rx_valid, tx_ready} == 5'b0, "R1 status",
          int'({busy, done, irq, rx_valid, tx_ready}), 0);

    // quad read frame: 1-line command, 4-line address/mode/dummy/data
    set_ph(0, 1, 0, 1); set_ph(1, 1, 2, 3); set_ph(2, 1, 2, 1);
    set_ph(3, 0, 2, 2); set_ph(4, 0, 2, 4);
    run_frame(0, 5, 1'b1, 1'b0, 1'b0);

    // dual lanes, slower clock, late transmit bytes
    set_ph(0, 1, 1, 2); set_ph(1, 0, 1, 2); set_ph(2, 0, 0, 2);
    run_frame(2, 3, 1'b1, 1'b1, 1'b0);

    // all eight phases, code 11 as four lanes, start poked while busy, no irq
    set_ph(0, 1, 0, 1); set_ph(1, 0, 0, 1); set_ph(2, 1, 1, 1); set_ph(3, 0, 1, 1);
    set_ph(4, 1, 3, 1); set_ph(5, 0, 3, 1); set_ph(6, 1, 2, 2); set_ph(7, 0, 0, 1);
    run_frame(1, 8, 1'b0, 1'b0, 1'b1);

    // phase count 12 folds to 8 (R3), with stalls
    run_frame(0, 12, 1'b1, 1'b1, 1'b0);

    // phase count 0 folds to 1 (R3)
    set_ph(0, 1, 1, 1);
    run_frame(3, 0, 1'b1, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule